// File: doc/BRIEF.md
# Page Address Translator with Associative Lookup Buffer

This block turns a logical address into a physical address. The address is cut into a page number (high bits) and a byte offset (low bits). The page number is first looked up in a small fully associative buffer of recent translations. On a hit the frame number comes straight from the buffer. On a miss the block reads one entry of a single-level page table in memory, checks it, stores it in the buffer and then answers. The offset is carried through unchanged.

The table sits at a base address held in a configuration register, and its size in entries is held in a length register. Both are loaded together through a configuration write strobe. A page number at or beyond the length is refused with a fault before any memory traffic. An entry whose valid bit is clear is refused with a different fault. A flush strobe empties the buffer. The system pulses it whenever the base register is changed. The block serves one translation at a time.

Top module: `page_xlate_top`

## Requirements
- R1: The physical address is the frame number in the high bits joined with the logical address's low log2(PAGE_BYTES) offset bits, unchanged. The page number is logical address bits [VA_W-1:OFF_W].
- R2: A page held in the buffer is answered with rsp_valid_o high on the second rising edge after the request is accepted, and no memory read is made.
- R3: A page missing from the buffer and below the length causes exactly one memory read, at cfg base + page * PTE_BYTES (2 by default). The answer follows the read data.
- R4: A page number greater than or equal to the length register gives rsp_fault_o = 1 and rsp_paddr_o = 0, on the second edge after acceptance, with no memory read.
- R5: A table entry with bit PTE_W-1 (the valid bit, bit 15 by default) clear gives rsp_fault_o = 2 and rsp_paddr_o = 0. Such an entry is not stored in the buffer, so a repeat of that page reads memory again. A valid entry gives rsp_fault_o = 0, with the frame taken from entry bits [FRAME_W-1:0].
- R6: A valid entry fetched on a miss is stored in the buffer, so the next request to the same page is a hit.
- R7: A fill goes to the lowest-numbered empty slot if one exists. Otherwise it goes to the slot named by a round-robin pointer that starts at 0 after reset and advances by one (wrapping) on each fill into a full buffer.
- R8: flush_i empties every slot in one cycle and wins over a fill in the same cycle. The next access to any page is a miss.
- R9: req_ready_o is high only when idle. It is low from the acceptance edge until the answer has been given. rsp_valid_o is a one-cycle pulse. A memory read is never requested while idle.
- R10: After reset, req_ready_o = 1, rsp_valid_o = 0, mem_req_o = 0, and base and length are 0, so every request faults with code 1. cfg_we_i loads both registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Load base and length registers |
| cfg_base_i | input | MEM_AW | Page table base address |
| cfg_len_i | input | VA_W-OFF_W+1 | Page table length in entries |
| flush_i | input | 1 | Empty the translation buffer |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Block idle, request accepted |
| req_addr_i | input | VA_W | Logical address |
| rsp_valid_o | output | 1 | Answer valid, one cycle |
| rsp_paddr_o | output | FRAME_W+OFF_W | Physical address, 0 on fault |
| rsp_fault_o | output | 2 | 0 none, 1 beyond length, 2 invalid entry |
| mem_req_o | output | 1 | Table read request, held until data |
| mem_addr_o | output | MEM_AW | Table entry address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | PTE_W | Table entry |

## Verification
Directed sequences try a repeated page, which separates a hit from a miss by latency and read count. They also try a page just below and just at the length, which tells the length fault apart from a walk. An entry with a clear valid bit, read twice, shows that bad entries are never stored. Filling all eight slots with distinct pages and then adding more tells first-empty placement apart from round-robin eviction. Random requests over pages both inside and outside the length, mixed with flushes and base changes, are checked against a bench model of the buffer that predicts the answer, the fault code, the read count and the read address.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;
  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_LEN  = 2'd1,
    FLT_INV  = 2'd2
  } fault_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_MEM,
    ST_RESP
  } walk_st_e;
endpackage

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     vld_i,
  input  logic             adv_i,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W-1:0] rr_q;
  logic             full;

  assign full = &vld_i;

  always_comb begin
    idx_o = rr_q;
    for (int i = N - 1; i >= 0; i--) begin
      if (!vld_i[i]) idx_o = IDX_W'(i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rr_q <= '0;
    end else if (adv_i && full) begin
      rr_q <= (rr_q == IDX_W'(N - 1)) ? '0 : rr_q + 1'b1;
    end
  end
endmodule

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int N     = 8,
  parameter int TAG_W = 10,
  parameter int FRM_W = 10,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic [TAG_W-1:0] lk_tag_i,
  output logic             hit_o,
  output logic [FRM_W-1:0] hit_frame_o,
  input  logic             fill_i,
  input  logic [IDX_W-1:0] fill_idx_i,
  input  logic [TAG_W-1:0] fill_tag_i,
  input  logic [FRM_W-1:0] fill_frame_i,
  output logic [N-1:0]     vld_o
);
  logic [N-1:0]     vld_q;
  logic [TAG_W-1:0] tag_q [N];
  logic [FRM_W-1:0] frm_q [N];
  logic [N-1:0]     match;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_ent
      assign match[g] = vld_q[g] && (tag_q[g] == lk_tag_i);

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          vld_q[g] <= 1'b0;
          tag_q[g] <= '0;
          frm_q[g] <= '0;
        end else if (flush_i) begin
          vld_q[g] <= 1'b0;
        end else if (fill_i && (fill_idx_i == IDX_W'(g))) begin
          vld_q[g] <= 1'b1;
          tag_q[g] <= fill_tag_i;
          frm_q[g] <= fill_frame_i;
        end
      end
    end
  endgenerate

  always_comb begin
    hit_frame_o = '0;
    for (int i = 0; i < N; i++) begin
      if (match[i]) hit_frame_o = hit_frame_o | frm_q[i];
    end
  end

  assign hit_o = |match;
  assign vld_o = vld_q;
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import tlbx_pkg::*;
#(
  parameter int VA_W      = 20,
  parameter int OFF_W     = 10,
  parameter int FRAME_W   = 10,
  parameter int MEM_AW    = 16,
  parameter int PTE_W     = 16,
  parameter int PTE_BYTES = 2,
  parameter int VPN_W     = VA_W - OFF_W,
  parameter int PA_W      = FRAME_W + OFF_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [VA_W-1:0]    req_addr_i,
  input  logic [MEM_AW-1:0]  base_i,
  input  logic [VPN_W:0]     len_i,
  output logic [VPN_W-1:0]   lk_tag_o,
  input  logic               hit_i,
  input  logic [FRAME_W-1:0] hit_frame_i,
  output logic               fill_o,
  output logic [FRAME_W-1:0] fill_frame_o,
  output logic               mem_req_o,
  output logic [MEM_AW-1:0]  mem_addr_o,
  input  logic               mem_rvalid_i,
  input  logic [PTE_W-1:0]   mem_rdata_i,
  output logic               rsp_valid_o,
  output logic [PA_W-1:0]    rsp_paddr_o,
  output logic [1:0]         rsp_fault_o
);
  localparam logic [MEM_AW-1:0] PTE_STEP = MEM_AW'(PTE_BYTES);

  walk_st_e          st_q, st_d;
  logic [VPN_W-1:0]  vpn_q;
  logic [OFF_W-1:0]  off_q;
  logic [PA_W-1:0]   pa_q, pa_d;
  fault_e            flt_q, flt_d;
  logic              beyond;
  logic              pte_ok;

  assign beyond       = {1'b0, vpn_q} >= len_i;
  assign pte_ok       = mem_rdata_i[PTE_W-1];
  assign lk_tag_o     = vpn_q;
  assign fill_frame_o = mem_rdata_i[FRAME_W-1:0];
  assign req_ready_o  = (st_q == ST_IDLE);
  assign mem_req_o    = (st_q == ST_MEM);
  assign mem_addr_o   = base_i + MEM_AW'(vpn_q) * PTE_STEP;
  assign rsp_valid_o  = (st_q == ST_RESP);
  assign rsp_paddr_o  = pa_q;
  assign rsp_fault_o  = flt_q;

  always_comb begin
    st_d   = st_q;
    pa_d   = pa_q;
    flt_d  = flt_q;
    fill_o = 1'b0;
    unique case (st_q)
      ST_IDLE: if (req_valid_i) st_d = ST_LOOK;
      ST_LOOK: begin
        if (beyond) begin
          pa_d  = '0;
          flt_d = FLT_LEN;
          st_d  = ST_RESP;
        end else if (hit_i) begin
          pa_d  = {hit_frame_i, off_q};
          flt_d = FLT_NONE;
          st_d  = ST_RESP;
        end else begin
          st_d = ST_MEM;
        end
      end
      ST_MEM: begin
        if (mem_rvalid_i) begin
          st_d = ST_RESP;
          if (pte_ok) begin
            fill_o = 1'b1;
            pa_d   = {mem_rdata_i[FRAME_W-1:0], off_q};
            flt_d  = FLT_NONE;
          end else begin
            pa_d  = '0;
            flt_d = FLT_INV;
          end
        end
      end
      ST_RESP: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      vpn_q <= '0;
      off_q <= '0;
      pa_q  <= '0;
      flt_q <= FLT_NONE;
    end else begin
      st_q  <= st_d;
      pa_q  <= pa_d;
      flt_q <= flt_d;
      if (st_q == ST_IDLE && req_valid_i) begin
        vpn_q <= req_addr_i[VA_W-1:OFF_W];
        off_q <= req_addr_i[OFF_W-1:0];
      end
    end
  end
endmodule

// File: rtl/page_xlate_top.sv
module page_xlate_top #(
  parameter int VA_W       = 20,
  parameter int PAGE_BYTES = 1024,
  parameter int FRAME_W    = 10,
  parameter int TLB_N      = 8,
  parameter int MEM_AW     = 16,
  parameter int PTE_W      = 16,
  parameter int PTE_BYTES  = 2,
  localparam int OFF_W     = $clog2(PAGE_BYTES),
  localparam int VPN_W     = VA_W - OFF_W,
  localparam int PA_W      = FRAME_W + OFF_W,
  localparam int IDX_W     = $clog2(TLB_N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [MEM_AW-1:0] cfg_base_i,
  input  logic [VPN_W:0]    cfg_len_i,
  input  logic              flush_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [VA_W-1:0]   req_addr_i,
  output logic              rsp_valid_o,
  output logic [PA_W-1:0]   rsp_paddr_o,
  output logic [1:0]        rsp_fault_o,
  output logic              mem_req_o,
  output logic [MEM_AW-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [PTE_W-1:0]  mem_rdata_i
);
  logic [MEM_AW-1:0]  base_q;
  logic [VPN_W:0]     len_q;
  logic [VPN_W-1:0]   lk_tag;
  logic               hit;
  logic [FRAME_W-1:0] hit_frame;
  logic               fill_req;
  logic               fill_en;
  logic [FRAME_W-1:0] fill_frame;
  logic [IDX_W-1:0]   victim;
  logic [TLB_N-1:0]   tlb_vld;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      len_q  <= '0;
    end else if (cfg_we_i) begin
      base_q <= cfg_base_i;
      len_q  <= cfg_len_i;
    end
  end

  // flush beats a fill landing in the same cycle
  assign fill_en = fill_req && !flush_i;

  pt_walker #(
    .VA_W(VA_W), .OFF_W(OFF_W), .FRAME_W(FRAME_W), .MEM_AW(MEM_AW),
    .PTE_W(PTE_W), .PTE_BYTES(PTE_BYTES)
  ) u_walk (
    .clk_i, .rst_ni, .req_valid_i, .req_ready_o, .req_addr_i,
    .base_i(base_q), .len_i(len_q), .lk_tag_o(lk_tag),
    .hit_i(hit), .hit_frame_i(hit_frame),
    .fill_o(fill_req), .fill_frame_o(fill_frame),
    .mem_req_o, .mem_addr_o, .mem_rvalid_i, .mem_rdata_i,
    .rsp_valid_o, .rsp_paddr_o, .rsp_fault_o
  );

  tlb_cam #(.N(TLB_N), .TAG_W(VPN_W), .FRM_W(FRAME_W)) u_cam (
    .clk_i, .rst_ni, .flush_i,
    .lk_tag_i(lk_tag), .hit_o(hit), .hit_frame_o(hit_frame),
    .fill_i(fill_en), .fill_idx_i(victim), .fill_tag_i(lk_tag),
    .fill_frame_i(fill_frame), .vld_o(tlb_vld)
  );

  tlb_victim #(.N(TLB_N)) u_vic (
    .clk_i, .rst_ni, .vld_i(tlb_vld), .adv_i(fill_en), .idx_o(victim)
  );
endmodule

// File: rtl/page_xlate_chk.sv
module page_xlate_chk #(
  parameter int N      = 8,
  parameter int PA_W   = 20,
  parameter int MEM_AW = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              flush_i,
  input logic              req_ready_o,
  input logic              rsp_valid_o,
  input logic [PA_W-1:0]   rsp_paddr_o,
  input logic [1:0]        rsp_fault_o,
  input logic              mem_req_o,
  input logic [MEM_AW-1:0] mem_addr_o,
  input logic              mem_rvalid_i,
  input logic [N-1:0]      tlb_vld
);
  AST_RSP_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !req_ready_o); // R9
  AST_RSP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o); // R9
  AST_MEM_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !req_ready_o); // R9
  AST_LEN_NO_MEM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o == 2'd1) |-> !$past(mem_req_o)); // R4
  AST_FAULT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o != 2'd0) |-> (rsp_paddr_o == '0)); // R5
  AST_FAULT_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (rsp_fault_o != 2'd3)); // R5
  AST_MEM_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && $past(mem_req_o) && !$past(mem_rvalid_i)) |-> $stable(mem_addr_o)); // R3
  AST_FLUSH_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (tlb_vld == '0)); // R8
endmodule

bind page_xlate_top page_xlate_chk #(.N(TLB_N), .PA_W(PA_W), .MEM_AW(MEM_AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(flush_i), .req_ready_o(req_ready_o),
  .rsp_valid_o(rsp_valid_o), .rsp_paddr_o(rsp_paddr_o), .rsp_fault_o(rsp_fault_o),
  .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_rvalid_i(mem_rvalid_i),
  .tlb_vld(tlb_vld)
);

// File: tb/page_xlate_top_test.sv
module page_xlate_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int VA_W = 20, OFF_W = 10, VPN_W = 10, FRAME_W = 10;
  localparam int PA_W = 20, MEM_AW = 16, PTE_W = 16, N = 8;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, flush = 0, req_valid = 0;
  logic [MEM_AW-1:0] cfg_base = '0;
  logic [VPN_W:0] cfg_len = '0;
  logic [VA_W-1:0] req_addr = '0;
  logic req_ready, rsp_valid, mem_req;
  logic [PA_W-1:0] rsp_paddr;
  logic [1:0] rsp_fault;
  logic [MEM_AW-1:0] mem_addr;
  logic mem_rvalid = 0;
  logic [PTE_W-1:0] mem_rdata = '0;

  int checks = 0, fails = 0, reads = 0, cyc = 0, dly = 0;
  logic [MEM_AW-1:0] last_maddr = '0;
  logic [MEM_AW-1:0] m_base = '0;
  int m_len = 0;
  bit m_v [N];
  int m_tag [N];
  int m_rr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  page_xlate_top uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_base_i(cfg_base),
    .cfg_len_i(cfg_len), .flush_i(flush), .req_valid_i(req_valid),
    .req_ready_o(req_ready), .req_addr_i(req_addr), .rsp_valid_o(rsp_valid),
    .rsp_paddr_o(rsp_paddr), .rsp_fault_o(rsp_fault), .mem_req_o(mem_req),
    .mem_addr_o(mem_addr), .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata)
  );

  function automatic bit pte_valid(int page);
    return (page % 5) != 3;
  endfunction
  function automatic logic [FRAME_W-1:0] pte_frame(int page);
    return FRAME_W'((page * 37 + 5) & 10'h3FF);
  endfunction

  // memory model, driven away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (mem_rvalid) mem_rvalid = 1'b0;
    else if (mem_req) begin
      if (dly == 0) begin
        int pg;
        pg = int'((mem_addr - m_base) >> 1);
        mem_rdata = {pte_valid(pg), 5'd0, pte_frame(pg)};
        mem_rvalid = 1'b1;
        reads++;
        last_maddr = mem_addr;
        dly = $urandom % 3;
      end else dly--;
    end
  end

  always @(negedge clk) if (cyc > 150000) begin
    fails++;
    $display("FAIL watchdog: run hung, actual=%0d expected<150000", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg(logic [MEM_AW-1:0] b, int l);
    @(negedge clk);
    cfg_we = 1; cfg_base = b; cfg_len = (VPN_W+1)'(l);
    @(negedge clk);
    cfg_we = 0;
    m_base = b; m_len = l;
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1;
    @(negedge clk);
    flush = 0;
    for (int i = 0; i < N; i++) m_v[i] = 0;
  endtask

  function automatic int m_find(int page);
    for (int i = 0; i < N; i++) if (m_v[i] && m_tag[i] == page) return i;
    return -1;
  endfunction

  function automatic void m_fill(int page);
    int slot;
    slot = -1;
    for (int i = N - 1; i >= 0; i--) if (!m_v[i]) slot = i;
    if (slot < 0) begin
      slot = m_rr;
      m_rr = (m_rr + 1) % N;
    end
    m_v[slot] = 1;
    m_tag[slot] = page;
  endfunction

  task automatic xl(logic [VA_W-1:0] va, string tag);
    int page, r0, lat, exp_rd;
    logic [PA_W-1:0] exp_pa;
    logic [1:0] exp_f;
    page = int'(va >> OFF_W);
    if (page >= m_len) begin
      exp_f = 2'd1; exp_pa = '0; exp_rd = 0;
    end else if (m_find(page) >= 0) begin
      exp_f = 2'd0; exp_pa = {pte_frame(page), va[OFF_W-1:0]}; exp_rd = 0;
    end else begin
      exp_rd = 1;
      if (pte_valid(page)) begin
        exp_f = 2'd0; exp_pa = {pte_frame(page), va[OFF_W-1:0]};
        m_fill(page);
      end else begin
        exp_f = 2'd2; exp_pa = '0;
      end
    end
    while (!req_ready) @(negedge clk);
    r0 = reads;
    req_valid = 1; req_addr = va;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    lat = 1;
    chk({tag, " R9 ready low while busy"}, 32'(req_ready), 0);
    while (!rsp_valid && lat < 50) begin
      @(negedge clk);
      lat++;
    end
    chk({tag, " R1 paddr"}, 32'(rsp_paddr), 32'(exp_pa));
    chk({tag, " R5 fault code"}, 32'(rsp_fault), 32'(exp_f));
    chk({tag, " R3 read count"}, 32'(reads - r0), 32'(exp_rd));
    if (exp_rd == 0) chk({tag, " R2 latency"}, 32'(lat), 2);
    else begin
      chk({tag, " R3 read address"}, 32'(last_maddr), 32'(m_base + MEM_AW'(page * 2)));
      chk({tag, " R3 answer after read"}, 32'(lat >= 3), 1);
    end
    @(negedge clk);
    chk({tag, " R9 rsp pulse"}, 32'(rsp_valid), 0);
  endtask

  initial begin
    int pl [9];
    void'($urandom(32'h5EED));
    for (int i = 0; i < N; i++) begin m_v[i] = 0; m_tag[i] = 0; end
    repeat (3) @(negedge clk);
    chk("R10 reset ready", 32'(req_ready), 1);
    chk("R10 reset rsp_valid", 32'(rsp_valid), 0);
    chk("R10 reset mem_req", 32'(mem_req), 0);
    rst_n = 1;
    @(negedge clk);
    xl(20'h00010, "R10 zero length faults R4");
    cfg(16'h1000, 40);
    xl({10'd5, 10'h123}, "R3 miss page5");
    xl({10'd5, 10'h3FF}, "R6 hit page5");
    xl({10'd3, 10'h001}, "R5 invalid page3");
    xl({10'd3, 10'h002}, "R5 invalid page3 again");
    xl({10'd40, 10'h000}, "R4 at length");
    xl({10'd39, 10'h2AA}, "R4 below length");
    xl({10'd39, 10'h055}, "R2 hit page39");
    do_flush();
    xl({10'd5, 10'h000}, "R8 after flush");
    do_flush();
    pl = '{10, 11, 12, 14, 15, 16, 17, 19, 20};
    for (int i = 0; i < 9; i++) xl({10'(pl[i]), 10'h010}, "R7 fill");
    xl({10'd11, 10'h000}, "R7 slot1 still held");
    xl({10'd10, 10'h000}, "R7 slot0 evicted");
    xl({10'd11, 10'h000}, "R7 slot1 evicted next");
    cfg(16'h2400, 44);
    do_flush();
    xl({10'd7, 10'h000}, "R3 new base");
    for (int k = 0; k < 400; k++) begin
      if ($urandom % 20 == 0) do_flush();
      if ($urandom % 60 == 0) begin
        cfg(16'(($urandom % 8) * 16'h0800), 36 + int'($urandom % 12));
        do_flush();
      end
      xl({10'($urandom % 48), 10'($urandom)}, "R6 random");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule